// File: doc/BRIEF.md
# PLL Control and Status Register

This block is the control and status register of a system PLL. Software uses a single-cycle write port to set the PLL enable, the keep-running-in-stop enable, the clock-monitor enable and the monitor action select. A write-lock bit can freeze those fields. The read port always returns the full register image. Writes take effect on the next rising clock edge.

The block turns a raw lock-detect input into a clock-valid flag. A strobe input sets the sampling rate, and the flag sets only after a run of consecutive locked samples. When the PLL is disabled, or when its oscillator reference reports an error, the flag drops at once and no error is recorded.

While the monitor is armed, a clock-fault input sets a sticky error flag. Depending on the action select, the flag drives either an interrupt line or a reset request line. The monitor is forced off in low-power modes. After such a mode ends, the monitor stays off until the valid flag sets again. In stop mode, the PLL enable output drops unless the stop enable bit is set.

Top module: `pll_ctrl_reg`

## Requirements
- R1: The register image has the following bits: bit 0 PLL enable, bit 1 stop enable, bit 16 monitor enable, bit 17 monitor action (1 = reset, 0 = interrupt), bit 23 write lock, bit 24 clock valid (read-only) and bit 26 clock error. Every other bit reads 0, and writes to those bits have no effect. After reset, the image reads 0.
- R2: While the write lock reads 1, a write leaves bits 0, 1, 16 and 17 unchanged. Every write loads bit 23 from the written data, whether the lock is set or not.
- R3: The valid flag sets on the third consecutive strobe (LOCK_SAMPLES = 3) that sees lock_raw high. A strobe with lock_raw low restarts the count at zero.
- R4: When the PLL enable reads 0, the valid flag reads 0. Disabling the PLL never sets the error flag.
- R5: While ref_is_osc and osc_err are both high, the valid flag reads 0, and a clock fault does not set the error flag. When ref_is_osc is low, osc_err has no effect.
- R6: When the error flag is 1, mon_irq equals 1 if the action bit is 0, and mon_rst_req equals 1 if the action bit is 1. Both outputs are 0 while the error flag is 0.
- R7: A fault sets the error flag only while the monitor enable is 1 and the valid flag is 1. Writing 1 to bit 26 clears the flag, and this works even while the lock is set. The flag is reported at most once until it is cleared.
- R8: While lp_mon_off is high, faults are ignored. After lp_mon_off falls, faults stay ignored until the valid flag rises again.
- R9: pll_en_out equals the PLL enable, except that it is 0 while stop_mode is high and the stop enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register image |
| lock_strobe | input | 1 | Lock sample strobe |
| lock_raw | input | 1 | Raw lock-detect level |
| ref_is_osc | input | 1 | PLL reference is the oscillator |
| osc_err | input | 1 | Oscillator error |
| clk_fault | input | 1 | Clock fault from the frequency comparator |
| lp_mon_off | input | 1 | Low-power mode that forces the monitor off |
| stop_mode | input | 1 | Chip is in stop mode |
| pll_en_out | output | 1 | Enable to the analog PLL |
| mon_irq | output | 1 | Monitor interrupt |
| mon_rst_req | output | 1 | Monitor reset request |

## Verification
A clock fault can arrive in the same cycle as an oscillator error, in the cycle that follows a disable write, or in the same cycle as a write-one-to-clear of the error flag. The bench raises the fault together with each of these events. It then judges the outcome from the error bit and the two action outputs: the loss of reference or of enable must mask the fault, and a clear must leave the flag at 0 for that cycle. The bench also checks that a fault arriving in the cycle after the clear is still reported.

// File: rtl/pll_csr_pkg.sv
// Package: bit positions and the control field type of the PLL register.
// Assumes a 32-bit register image.
package pll_csr_pkg;
    localparam int REG_W  = 32;
    localparam int B_EN   = 0;
    localparam int B_STEN = 1;
    localparam int B_CM   = 16;
    localparam int B_CMRE = 17;
    localparam int B_LK   = 23;
    localparam int B_VLD  = 24;
    localparam int B_ERR  = 26;

    typedef struct packed {
        logic lk;
        logic cmre;
        logic cm;
        logic sten;
        logic en;
    } pll_ctrl_t;
endpackage

// File: rtl/pll_lock_qual.sv
// Module: turns the raw lock level into a valid flag. The flag needs
// SAMPLES consecutive locked strobes. Assumes enable_i is already
// masked by a reference failure; when enable_i drops, the flag clears
// in the same cycle.
module pll_lock_qual #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic strobe_i,
    input  logic lock_i,
    output logic valid_o
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [CW-1:0] cnt_q;
    logic          vld_q;

    // Count consecutive locked samples and latch the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else if (strobe_i) begin
            if (!lock_i) begin
                cnt_q <= '0;
            end else if (cnt_q != CW'(SAMPLES)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (lock_i && cnt_q == LAST) begin
                vld_q <= 1'b1;
            end
        end
    end

    assign valid_o = vld_q & enable_i;
endmodule

// File: rtl/pll_clk_mon.sv
// Module: the clock monitor. It arms on enable plus valid, it is held
// off by low-power modes until valid rises again, and it keeps a sticky
// error flag that drives either an interrupt or a reset request.
module pll_clk_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en_i,
    input  logic rst_sel_i,
    input  logic valid_i,
    input  logic lp_off_i,
    input  logic fault_i,
    input  logic clr_i,
    output logic err_o,
    output logic irq_o,
    output logic rst_req_o
);
    logic blocked_q;
    logic vld_d_q;
    logic err_q;
    logic armed;

    // Remember the previous valid level to detect a new lock.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_d_q <= 1'b0;
        else        vld_d_q <= valid_i;
    end

    // Block the monitor from low-power entry until valid rises again.
    always_ff @(posedge clk) begin
        if (!rst_n)                    blocked_q <= 1'b0;
        else if (lp_off_i)             blocked_q <= 1'b1;
        else if (valid_i && !vld_d_q)  blocked_q <= 1'b0;
    end

    assign armed = mon_en_i & valid_i & ~blocked_q & ~lp_off_i;

    // Sticky error: a clear ends it, and a new fault is accepted only
    // while the flag is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)     err_q <= 1'b0;
        else if (err_q) err_q <= ~clr_i;
        else            err_q <= armed & fault_i;
    end

    assign err_o     = err_q;
    assign irq_o     = err_q & ~rst_sel_i;
    assign rst_req_o = err_q &  rst_sel_i;
endmodule

// File: rtl/pll_ctrl_reg.sv
// Module: top of the PLL control and status register. It holds the
// control fields and the write lock, builds the read image and joins the
// lock qualifier with the clock monitor. Writes land at the next clock edge.
module pll_ctrl_reg
    import pll_csr_pkg::*;
#(
    parameter int LOCK_SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             lock_strobe,
    input  logic             lock_raw,
    input  logic             ref_is_osc,
    input  logic             osc_err,
    input  logic             clk_fault,
    input  logic             lp_mon_off,
    input  logic             stop_mode,
    output logic             pll_en_out,
    output logic             mon_irq,
    output logic             mon_rst_req
);
    pll_ctrl_t ctl_q;
    logic      ref_fail;
    logic      qual_en;
    logic      valid;
    logic      err;
    logic      err_clr;
    logic      wr_unused;

    assign wr_unused = ^{wr_data[31:27], wr_data[25:24], wr_data[22:18], wr_data[15:2]};

    // Control fields: the lock bit is always writable, the rest only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q.lk <= wr_data[B_LK];
            if (!ctl_q.lk) begin
                ctl_q.en   <= wr_data[B_EN];
                ctl_q.sten <= wr_data[B_STEN];
                ctl_q.cm   <= wr_data[B_CM];
                ctl_q.cmre <= wr_data[B_CMRE];
            end
        end
    end

    assign ref_fail = ref_is_osc & osc_err;
    assign qual_en  = ctl_q.en & ~ref_fail;
    assign err_clr  = wr_en & wr_data[B_ERR];

    pll_lock_qual #(.SAMPLES(LOCK_SAMPLES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (qual_en),
        .strobe_i (lock_strobe),
        .lock_i   (lock_raw),
        .valid_o  (valid)
    );

    pll_clk_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en_i  (ctl_q.cm),
        .rst_sel_i (ctl_q.cmre),
        .valid_i   (valid),
        .lp_off_i  (lp_mon_off),
        .fault_i   (clk_fault),
        .clr_i     (err_clr),
        .err_o     (err),
        .irq_o     (mon_irq),
        .rst_req_o (mon_rst_req)
    );

    // Build the read image; all unassigned bits stay zero.
    always_comb begin
        rd_data         = '0;
        rd_data[B_EN]   = ctl_q.en;
        rd_data[B_STEN] = ctl_q.sten;
        rd_data[B_CM]   = ctl_q.cm;
        rd_data[B_CMRE] = ctl_q.cmre;
        rd_data[B_LK]   = ctl_q.lk;
        rd_data[B_VLD]  = valid;
        rd_data[B_ERR]  = err;
    end

    assign pll_en_out = ctl_q.en & (~stop_mode | ctl_q.sten);
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
// Checker: temporal properties of the PLL register, attached by bind.
module pll_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        lock_strobe,
    input logic        lock_raw,
    input logic        ref_is_osc,
    input logic        osc_err,
    input logic        lp_mon_off,
    input logic        stop_mode,
    input logic        pll_en_out,
    input logic        mon_irq,
    input logic        mon_rst_req
);
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[23]) |=> (rd_data[17:16] == $past(rd_data[17:16]) && rd_data[1:0] == $past(rd_data[1:0]))); // R2
    AST_VLD_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[24]) |-> $past(lock_strobe && lock_raw)); // R3
    AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[24] |-> rd_data[0]); // R4
    AST_DIS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |=> !$rose(rd_data[26])); // R4
    AST_REF_FAIL_DROPS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_is_osc && osc_err) |-> !rd_data[24]); // R5
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_irq |-> (rd_data[26] && !rd_data[17] && !mon_rst_req)); // R6
    AST_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mon_rst_req |-> (rd_data[26] && rd_data[17])); // R6
    AST_LP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mon_off && !rd_data[26]) |=> !rd_data[26]); // R8
    AST_STOP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !rd_data[1]) |-> !pll_en_out); // R9
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .lock_strobe (lock_strobe),
    .lock_raw    (lock_raw),
    .ref_is_osc  (ref_is_osc),
    .osc_err     (osc_err),
    .lp_mon_off  (lp_mon_off),
    .stop_mode   (stop_mode),
    .pll_en_out  (pll_en_out),
    .mon_irq     (mon_irq),
    .mon_rst_req (mon_rst_req)
);

// File: tb/sim_pll_ctrl_reg.sv
module sim_pll_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lock_strobe = 1'b0, lock_raw = 1'b0;
    logic        ref_is_osc = 1'b0, osc_err = 1'b0;
    logic        clk_fault = 1'b0, lp_mon_off = 1'b0, stop_mode = 1'b0;
    logic        pll_en_out, mon_irq, mon_rst_req;
    int          checks = 0, errors = 0, cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pll_ctrl_reg u0 (.*);

    // Expected image from field values.
    function automatic logic [31:0] img(input bit lk, cmre, cm, sten, en, vld, err);
        return (32'(err) << 26) | (32'(vld) << 24) | (32'(lk) << 23) |
               (32'(cmre) << 17) | (32'(cm) << 16) | (32'(sten) << 1) | 32'(en);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic smp(input bit l);
        @(negedge clk); lock_raw = l; lock_strobe = 1'b1;
        @(negedge clk); lock_strobe = 1'b0;
    endtask

    task automatic fault1();
        @(negedge clk); clk_fault = 1'b1;
        @(negedge clk); clk_fault = 1'b0;
    endtask

    task automatic relock(input logic [31:0] ctl);
        wr(32'h0); wr(ctl);
        for (int k = 0; k < 3; k++) smp(1'b1);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data, 32'h0, "R1 reset image");

        // R1: write all ones, only defined writable bits stick.
        wr(32'hFBFF_FFFF);
        chk(rd_data, img(1,1,1,1,1,0,0), "R1 all-ones write");

        // R2: locked write changes nothing but lock.
        wr(32'h0003_0003);
        chk(rd_data, img(0,1,1,1,1,0,0), "R2 unlock only");
        wr(32'h0080_0000);
        chk(rd_data, img(1,0,0,0,0,0,0), "R2 lock with fields");
        wr(32'h0003_0003);
        chk(rd_data, 32'h0, "R2 locked write ignored");
        wr(32'h0003_0003);
        chk(rd_data, img(0,1,1,1,1,0,0), "R2 write after unlock");

        // R9: sweep stop_mode x sten x en.
        for (int v = 0; v < 8; v++) begin
            wr({16'h0, 14'h0, v[1], v[0]});
            stop_mode = v[2];
            @(negedge clk);
            chk({31'h0, pll_en_out}, {31'h0, v[0] & (~v[2] | v[1])}, "R9 stop gating");
        end
        stop_mode = 1'b0;

        // R3: sweep runs of n locked samples.
        for (int n = 0; n < 6; n++) begin
            wr(32'h0); wr(32'h0000_0001);
            for (int k = 0; k < n; k++) smp(1'b1);
            chk({31'h0, rd_data[24]}, {31'h0, 1'(n >= 3)}, "R3 run length");
        end
        wr(32'h0); wr(32'h0000_0001);
        smp(1); smp(1); smp(0); smp(1); smp(1);
        chk({31'h0, rd_data[24]}, 32'h0, "R3 broken run");
        smp(1);
        chk({31'h0, rd_data[24]}, 32'h1, "R3 run after restart");

        // R6/R7: interrupt mode fault.
        relock(32'h0001_0001);
        fault1();
        chk({rd_data, 30'h0, mon_irq, mon_rst_req}, {img(0,0,1,0,1,1,1), 32'h2}, "R6 irq mode");
        fault1();
        chk({31'h0, rd_data[26]}, 32'h1, "R7 single report");
        // R7: clear while locked, fault on the clear cycle is dropped.
        wr(32'h0081_0001);
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0481_0001; clk_fault = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        chk({31'h0, rd_data[26]}, 32'h0, "R7 clear beats fault while locked");
        @(negedge clk); clk_fault = 1'b0;
        chk({31'h0, rd_data[26]}, 32'h1, "R7 fault after clear");
        wr(32'h0401_0001);
        chk(rd_data, img(0,0,0,0,0,0,0) | img(0,0,1,0,1,1,0), "R2 unlock keeps fields");

        // R7: monitor disabled ignores faults.
        relock(32'h0000_0001);
        fault1();
        chk({31'h0, rd_data[26]}, 32'h0, "R7 monitor off");

        // R6: reset mode.
        relock(32'h0003_0001);
        fault1();
        chk({30'h0, mon_irq, mon_rst_req}, 32'h1, "R6 reset mode");
        wr(32'h0403_0001);

        // R4: disable, then fault next cycle.
        wr(32'h0003_0000);
        chk({31'h0, rd_data[24]}, 32'h0, "R4 valid drop");
        fault1();
        chk({rd_data[26], mon_irq, mon_rst_req}, 3'b000, "R4 no error after disable");

        // R5: ref failure coincides with fault.
        relock(32'h0001_0001);
        ref_is_osc = 1'b0; osc_err = 1'b1;
        @(negedge clk);
        chk({31'h0, rd_data[24]}, 32'h1, "R5 osc err ignored when not reference");
        ref_is_osc = 1'b1; clk_fault = 1'b1;
        @(negedge clk);
        chk({31'h0, rd_data[24]}, 32'h0, "R5 valid drop");
        @(negedge clk); clk_fault = 1'b0; osc_err = 1'b0; ref_is_osc = 1'b0;
        chk({31'h0, rd_data[26]}, 32'h0, "R5 no error on ref fail");

        // R8: low-power blocks until relock.
        relock(32'h0001_0001);
        @(negedge clk); lp_mon_off = 1'b1; clk_fault = 1'b1;
        @(negedge clk); lp_mon_off = 1'b0; clk_fault = 1'b0;
        chk({31'h0, rd_data[26]}, 32'h0, "R8 fault during low power");
        fault1();
        chk({31'h0, rd_data[26]}, 32'h0, "R8 blocked after exit");
        relock(32'h0001_0001);
        fault1();
        chk({31'h0, rd_data[26]}, 32'h1, "R8 rearmed after relock");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule